// File: doc/BRIEF.md
# Eight-bit ALU with status flags

This block is the arithmetic and logic datapath of a small register-to-register processor core. Each cycle it accepts an operation code, two operands (any choice between a register value and an immediate has already been made upstream), the current carry flag and the current zero flag. It then produces the result byte, the six status flag values and a write-enable mask that tells the status register which flags this operation updates. Flags outside the mask keep their stored value, so an increment leaves carry alone and a nibble swap leaves every flag alone.

Arithmetic covers add and subtract, each with and without the incoming carry, plus two's complement, increment and decrement. The logic group covers AND, OR, XOR, one's complement and nibble swap. The shift group covers logical shifts left and right, arithmetic shift right, and rotates left and right through carry. Subtract-with-carry folds the previous zero flag into the new one, so a compare over several bytes, done least significant byte first, ends with a zero flag that describes the whole word.

The result, flags and mask are registered. They appear one clock after the inputs are presented. A synchronous active-high reset clears all three.

Top module: `alu8_core`

## Requirements
- R1: Outputs are registered. Inputs sampled at one rising edge appear on `res_o`, `flags_o` and `flag_we_o` after that edge. While `rst` is high at an edge, all three outputs are cleared to zero.
- R2: Op 0 (add) and op 1 (add with `c_in`) return (a + b [+ c_in]) mod 256. C is the carry out of bit 7, H is the carry out of bit 3, and V flags a signed overflow. The mask covers all six flags.
- R3: Op 2 (subtract) and op 3 (subtract with `c_in`) return (a − b [− c_in]) mod 256. C is set on a borrow out of bit 7, H on a borrow out of bit 3, and V on a signed overflow. The mask covers all six flags.
- R4: For op 3, Z is 1 only if the result is zero and `z_in` is 1. For every other op that writes Z, Z depends on the result alone.
- R5: Flag bit positions in `flags_o` and `flag_we_o` are C=0, Z=1, N=2, V=3, S=4, H=5. N is result bit 7. S equals N XOR V whenever S is written. A flag bit whose enable is 0 reads 0.
- R6: Op 4 (AND), op 5 (OR) and op 6 (XOR) return the bitwise result with V=0. The mask is Z, N, V, S only.
- R7: Op 7 (one's complement of a) returns 0xFF − a with C=1 and V=0. The mask is C, Z, N, V, S.
- R8: Op 8 (two's complement of a) returns 0x00 − a. C is set unless a is 0, V is set only for a = 0x80, and H is the borrow out of bit 3. The mask covers all six flags.
- R9: Op 9 (increment a) and op 10 (decrement a) wrap modulo 256. V is set only when a is 0x7F (increment) or 0x80 (decrement). The mask is Z, N, V, S, so C and H are preserved.
- R10: Op 11 shifts left with 0 in. Op 12 shifts right with 0 in. Op 13 rotates left through carry. Op 14 rotates right through carry. Op 15 shifts right arithmetically, keeping bit 7. In each case C takes the bit shifted out and V = N XOR C. The mask is C, Z, N, V, S.
- R11: Op 16 exchanges the high and low nibbles of a, and the mask is zero.
- R12: Op codes 17 to 31 give a zero result, zero flags and a zero mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 5 | Operation code |
| a_i | input | WIDTH | First operand (the only operand for single-operand ops) |
| b_i | input | WIDTH | Second operand |
| c_in | input | 1 | Current carry flag |
| z_in | input | 1 | Current zero flag, used by subtract with carry |
| res_o | output | WIDTH | Registered result |
| flags_o | output | 6 | Registered flag values {H,S,V,N,Z,C} |
| flag_we_o | output | 6 | Registered per-flag write enable, same bit layout |

## Verification
All three outputs belong to the inputs present at the previous rising edge: there is one register stage and no other latency. The bench changes the inputs at a falling edge and compares the outputs at the next falling edge, one full cycle later, so every comparison sees exactly one capture. The reset check holds `rst` high across an edge with inputs that would give a nonzero result, and expects zeros on the following falling edge.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int OPW = 5;
  localparam int NFLAG = 6;

  // flag bit positions shared by flags and enable mask
  localparam int FC = 0;
  localparam int FZ = 1;
  localparam int FN = 2;
  localparam int FV = 3;
  localparam int FS = 4;
  localparam int FH = 5;

  localparam logic [OPW-1:0] OP_ADD  = 5'd0;
  localparam logic [OPW-1:0] OP_ADC  = 5'd1;
  localparam logic [OPW-1:0] OP_SUB  = 5'd2;
  localparam logic [OPW-1:0] OP_SBC  = 5'd3;
  localparam logic [OPW-1:0] OP_AND  = 5'd4;
  localparam logic [OPW-1:0] OP_OR   = 5'd5;
  localparam logic [OPW-1:0] OP_XOR  = 5'd6;
  localparam logic [OPW-1:0] OP_COM  = 5'd7;
  localparam logic [OPW-1:0] OP_NEG  = 5'd8;
  localparam logic [OPW-1:0] OP_INC  = 5'd9;
  localparam logic [OPW-1:0] OP_DEC  = 5'd10;
  localparam logic [OPW-1:0] OP_LSL  = 5'd11;
  localparam logic [OPW-1:0] OP_LSR  = 5'd12;
  localparam logic [OPW-1:0] OP_ROL  = 5'd13;
  localparam logic [OPW-1:0] OP_ROR  = 5'd14;
  localparam logic [OPW-1:0] OP_ASR  = 5'd15;
  localparam logic [OPW-1:0] OP_SWAP = 5'd16;

  localparam logic [NFLAG-1:0] M_ALL   = 6'b111111;
  localparam logic [NFLAG-1:0] M_ZNVS  = 6'b011110;
  localparam logic [NFLAG-1:0] M_CZNVS = 6'b011111;
endpackage

// File: rtl/alu8_arith.sv
module alu8_arith
  import alu8_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [OPW-1:0]   op,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  input  logic             zin,
  output logic [WIDTH-1:0] res,
  output logic [NFLAG-1:0] fl,
  output logic [NFLAG-1:0] we
);
  localparam int HB = WIDTH / 2;

  logic [WIDTH-1:0] x, y, r;
  logic             ci, sub, hit, chain;
  logic [NFLAG-1:0] mask;
  logic [WIDTH:0]   full;
  logic [HB:0]      low;
  logic             vf, nf, zf;

  // operand steering: every op in this unit is x +/- y +/- ci
  always_comb begin
    x     = a;
    y     = b;
    ci    = 1'b0;
    sub   = 1'b0;
    hit   = 1'b1;
    chain = 1'b0;
    mask  = M_ALL;
    case (op)
      OP_ADD: ;
      OP_ADC: ci = cin;
      OP_SUB: sub = 1'b1;
      OP_SBC: begin sub = 1'b1; ci = cin; chain = 1'b1; end
      OP_NEG: begin sub = 1'b1; x = '0; y = a; end
      OP_INC: begin y = WIDTH'(1); mask = M_ZNVS; end
      OP_DEC: begin y = WIDTH'(1); sub = 1'b1; mask = M_ZNVS; end
      default: begin hit = 1'b0; mask = '0; end
    endcase
  end

  always_comb begin
    if (sub) begin
      full = {1'b0, x} - {1'b0, y} - {{WIDTH{1'b0}}, ci};
      low  = {1'b0, x[HB-1:0]} - {1'b0, y[HB-1:0]} - {{HB{1'b0}}, ci};
    end else begin
      full = {1'b0, x} + {1'b0, y} + {{WIDTH{1'b0}}, ci};
      low  = {1'b0, x[HB-1:0]} + {1'b0, y[HB-1:0]} + {{HB{1'b0}}, ci};
    end
    r  = full[WIDTH-1:0];
    nf = r[WIDTH-1];
    zf = (r == '0) && (!chain || zin);
    if (sub)
      vf = (x[WIDTH-1] != y[WIDTH-1]) && (nf != x[WIDTH-1]);
    else
      vf = (x[WIDTH-1] == y[WIDTH-1]) && (nf != x[WIDTH-1]);
  end

  always_comb begin
    fl      = '0;
    fl[FC]  = full[WIDTH];
    fl[FZ]  = zf;
    fl[FN]  = nf;
    fl[FV]  = vf;
    fl[FS]  = nf ^ vf;
    fl[FH]  = low[HB];
    fl      = fl & mask;
    we      = mask;
    res     = hit ? r : '0;
  end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [OPW-1:0]   op,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] res,
  output logic [NFLAG-1:0] fl,
  output logic [NFLAG-1:0] we
);
  localparam int HB = WIDTH / 2;

  logic [WIDTH-1:0] r;
  logic [NFLAG-1:0] mask;
  logic             cset;

  always_comb begin
    r    = '0;
    mask = M_ZNVS;
    cset = 1'b0;
    case (op)
      OP_AND:  r = a & b;
      OP_OR:   r = a | b;
      OP_XOR:  r = a ^ b;
      OP_COM:  begin r = ~a; mask = M_CZNVS; cset = 1'b1; end
      OP_SWAP: begin r = {a[HB-1:0], a[WIDTH-1:HB]}; mask = '0; end
      default: mask = '0;
    endcase
  end

  always_comb begin
    fl     = '0;
    fl[FC] = cset;
    fl[FZ] = (r == '0);
    fl[FN] = r[WIDTH-1];
    fl[FV] = 1'b0;
    fl[FS] = r[WIDTH-1];
    fl     = fl & mask;
    we     = mask;
    res    = r;
  end
endmodule

// File: rtl/alu8_shift.sv
module alu8_shift
  import alu8_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [OPW-1:0]   op,
  input  logic [WIDTH-1:0] a,
  input  logic             cin,
  output logic [WIDTH-1:0] res,
  output logic [NFLAG-1:0] fl,
  output logic [NFLAG-1:0] we
);
  logic [WIDTH-1:0] r;
  logic             cout, hit, nf, vf;

  always_comb begin
    r    = '0;
    cout = 1'b0;
    hit  = 1'b1;
    case (op)
      OP_LSL: begin r = {a[WIDTH-2:0], 1'b0};       cout = a[WIDTH-1]; end
      OP_ROL: begin r = {a[WIDTH-2:0], cin};        cout = a[WIDTH-1]; end
      OP_LSR: begin r = {1'b0, a[WIDTH-1:1]};       cout = a[0]; end
      OP_ROR: begin r = {cin, a[WIDTH-1:1]};        cout = a[0]; end
      OP_ASR: begin r = {a[WIDTH-1], a[WIDTH-1:1]}; cout = a[0]; end
      default: hit = 1'b0;
    endcase
  end

  always_comb begin
    nf     = r[WIDTH-1];
    vf     = nf ^ cout;
    fl     = '0;
    fl[FC] = cout;
    fl[FZ] = (r == '0);
    fl[FN] = nf;
    fl[FV] = vf;
    fl[FS] = nf ^ vf;
    we     = hit ? M_CZNVS : '0;
    fl     = fl & we;
    res    = r;
  end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [4:0]       op_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             c_in,
  input  logic             z_in,
  output logic [WIDTH-1:0] res_o,
  output logic [5:0]       flags_o,
  output logic [5:0]       flag_we_o
);
  localparam int NUNIT = 3;

  logic [NUNIT-1:0][WIDTH-1:0] u_res;
  logic [NUNIT-1:0][NFLAG-1:0] u_fl;
  logic [NUNIT-1:0][NFLAG-1:0] u_we;

  alu8_arith #(.WIDTH(WIDTH)) u_arith (
    .op(op_i), .a(a_i), .b(b_i), .cin(c_in), .zin(z_in),
    .res(u_res[0]), .fl(u_fl[0]), .we(u_we[0])
  );

  alu8_logic #(.WIDTH(WIDTH)) u_logic (
    .op(op_i), .a(a_i), .b(b_i),
    .res(u_res[1]), .fl(u_fl[1]), .we(u_we[1])
  );

  alu8_shift #(.WIDTH(WIDTH)) u_shift (
    .op(op_i), .a(a_i), .cin(c_in),
    .res(u_res[2]), .fl(u_fl[2]), .we(u_we[2])
  );

  // each unit drives zeros for codes it does not own, so an OR merges them
  logic [WIDTH-1:0] res_d;
  logic [NFLAG-1:0] fl_d, we_d;

  always_comb begin
    res_d = '0;
    fl_d  = '0;
    we_d  = '0;
    for (int i = 0; i < NUNIT; i++) begin
      res_d = res_d | u_res[i];
      fl_d  = fl_d  | u_fl[i];
      we_d  = we_d  | u_we[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_o     <= '0;
      flags_o   <= '0;
      flag_we_o <= '0;
    end else begin
      res_o     <= res_d;
      flags_o   <= fl_d;
      flag_we_o <= we_d;
    end
  end

  // R1: an edge with reset high leaves all outputs cleared
  a_r1_reset_clears: assert property (@(posedge clk)
    $past(rst) |-> (res_o == '0 && flags_o == '0 && flag_we_o == '0));

  // R5: sign flag consistent with N and V
  a_r5_sign_is_n_xor_v: assert property (@(posedge clk) disable iff (rst)
    flag_we_o[FS] |-> (flags_o[FS] == (flags_o[FN] ^ flags_o[FV])));

  // R5: disabled flags read zero
  a_r5_masked_zero: assert property (@(posedge clk) disable iff (rst)
    (flags_o & ~flag_we_o) == '0);

  // R9: increment and decrement never touch C or H
  a_r9_incdec_keep_c: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(op_i) == OP_INC || $past(op_i) == OP_DEC))
      |-> (!flag_we_o[FC] && !flag_we_o[FH]));

  // R6: logic ops clear V
  a_r6_logic_v_clear: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(op_i) == OP_AND || $past(op_i) == OP_OR ||
                     $past(op_i) == OP_XOR)) |-> (flag_we_o[FV] && !flags_o[FV]));

  // R11: swap writes no flag
  a_r11_swap_quiet: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_i) == OP_SWAP) |-> (flag_we_o == '0));

  // R12: unused codes give nothing
  a_r12_bad_op_quiet: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_i) > OP_SWAP) |-> (res_o == '0 && flag_we_o == '0));

  // R4: chained zero never set when incoming zero was clear
  a_r4_chain_zero: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_i) == OP_SBC && !$past(z_in)) |-> !flags_o[FZ]);
endmodule

// File: tb/alu8_core_bench.sv
module alu8_core_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] op_i = '0;
  logic [7:0] a_i = '0, b_i = '0;
  logic       c_in = 1'b0, z_in = 1'b0;
  logic [7:0] res_o;
  logic [5:0] flags_o, flag_we_o;

  int n_run = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu8_core #(.WIDTH(8)) u_alu8_core (
    .clk(clk), .rst(rst), .op_i(op_i), .a_i(a_i), .b_i(b_i),
    .c_in(c_in), .z_in(z_in), .res_o(res_o), .flags_o(flags_o),
    .flag_we_o(flag_we_o)
  );

  function automatic int sx(int v);
    return (v > 127) ? v - 256 : v;
  endfunction

  function automatic string tag_of(int op);
    case (op)
      0, 1:    return "R2";
      2:       return "R3";
      3:       return "R4";
      4, 5, 6: return "R6";
      7:       return "R7";
      8:       return "R8";
      9, 10:   return "R9";
      11, 12, 13, 14, 15: return "R10";
      16:      return "R11";
      default: return "R12";
    endcase
  endfunction

  // expected {mask, flags, result}; flag order H S V N Z C (bits 5..0)
  function automatic logic [19:0] model(int op, int a, int b, int c, int z);
    int r, cf, zf, nf, vf, hf, sv, ci;
    logic [5:0] m;
    r = 0; cf = 0; zf = 0; nf = 0; vf = 0; hf = 0; m = 6'b0;
    ci = (op == 1 || op == 3) ? c : 0;
    case (op)
      0, 1: begin
        r = a + b + ci; cf = (r > 255); hf = ((a % 16) + (b % 16) + ci) > 15;
        sv = sx(a) + sx(b) + ci; vf = (sv > 127 || sv < -128); m = 6'h3F;
      end
      2, 3, 8: begin
        int p, q;
        p = (op == 8) ? 0 : a; q = (op == 8) ? a : b;
        r = p - q - ci; cf = (r < 0); hf = ((p % 16) - (q % 16) - ci) < 0;
        sv = sx(p) - sx(q) - ci; vf = (sv > 127 || sv < -128); m = 6'h3F;
      end
      4: begin r = a & b; m = 6'h1E; end
      5: begin r = a | b; m = 6'h1E; end
      6: begin r = a ^ b; m = 6'h1E; end
      7: begin r = 255 - a; cf = 1; m = 6'h1F; end
      9:  begin r = a + 1; vf = (a == 127); m = 6'h1E; end
      10: begin r = a - 1; vf = (a == 128); m = 6'h1E; end
      11: begin r = a * 2;               cf = a / 128; m = 6'h1F; end
      12: begin r = a / 2;               cf = a % 2;   m = 6'h1F; end
      13: begin r = a * 2 + c;           cf = a / 128; m = 6'h1F; end
      14: begin r = a / 2 + 128 * c;     cf = a % 2;   m = 6'h1F; end
      15: begin r = a / 2 + (a & 128);   cf = a % 2;   m = 6'h1F; end
      16: begin r = (a % 16) * 16 + a / 16; end
      default: ;
    endcase
    r  = r & 255;
    nf = (r > 127);
    if (op >= 11 && op <= 15) vf = nf ^ cf;
    zf = (r == 0) && (op != 3 || z == 1);
    model = {m, m & {hf[0], nf[0] ^ vf[0], vf[0], nf[0], zf[0], cf[0]}, r[7:0]};
  endfunction

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  task automatic check(string tag, logic [19:0] exp);
    n_run++;
    if ({flag_we_o, flags_o, res_o} !== exp) begin
      n_fail++;
      $display("FAIL %s op=%0d a=%02h b=%02h c=%0b z=%0b got we/fl/res=%02h/%02h/%02h exp=%02h/%02h/%02h",
               tag, op_i, a_i, b_i, c_in, z_in, flag_we_o, flags_o, res_o,
               exp[19:14], exp[13:8], exp[7:0]);
    end
  endtask

  task automatic apply(int op, int a, int b, int c, int z);
    op_i = op[4:0]; a_i = a[7:0]; b_i = b[7:0]; c_in = c[0]; z_in = z[0];
    @(negedge clk);
    check(tag_of(op), model(op, a, b, c, z));
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R1: reset with inputs that would give a nonzero result
    op_i = 5'd0; a_i = 8'h7F; b_i = 8'h01; c_in = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", 20'h0);
    rst = 1'b0;
    // R1: one-cycle latency, then reset mid-run clears
    apply(0, 8'h7F, 8'h01, 0, 0);
    rst = 1'b1; op_i = 5'd3; a_i = 8'h10; b_i = 8'h20;
    @(negedge clk);
    check("R1", 20'h0);
    rst = 1'b0;

    // directed corners
    apply(3, 8'h00, 8'h00, 0, 0);   // R4: zero result but chain broken
    apply(3, 8'h00, 8'h00, 0, 1);   // R4: zero with chain
    apply(8, 8'h80, 0, 0, 0);       // R8: overflow case
    apply(8, 8'h00, 0, 0, 0);       // R8: no borrow
    apply(9, 8'h7F, 0, 1, 0);       // R9
    apply(10, 8'h80, 0, 1, 0);      // R9
    apply(7, 8'hFF, 0, 0, 0);       // R7: zero result, C forced

    // two-operand sweeps (R2 R3 R4 R6)
    for (int op = 0; op <= 6; op++)
      for (int z = (op == 3) ? 0 : 1; z <= 1; z++)
        for (int c = 0; c <= 1; c++)
          for (int b = 0; b < 256; b += 17)
            for (int a = 0; a < 256; a++)
              apply(op, a, b, c, z);

    // single-operand sweeps (R5 R7 R8 R9 R10 R11)
    for (int op = 7; op <= 16; op++)
      for (int c = 0; c <= 1; c++)
        for (int a = 0; a < 256; a++)
          apply(op, a, 8'h5A, c, 1);

    // R12: undefined codes
    for (int op = 17; op < 32; op++)
      for (int a = 0; a < 256; a += 51)
        apply(op, a, 255 - a, 1, 1);

    finish_run();
  end
endmodule